// File: doc/BRIEF.md
# Multi-Mode Reloadable Timer Group

A group of six 16-bit timer channels. Each channel has a counter and a reload register. In timer mode and event mode the counter counts down and reloads on underflow. In measurement mode it counts up and captures its value at selected edges of its input pin. Each channel's settings arrive as per-channel configuration vectors: a mode field, a source field, an edge field and a start bit. The four prescaled clock enables are shared by all channels, and each is a one-cycle pulse. Bus decoding and the prescaler divider stay outside the block.

The host writes the reload register one byte at a time. While a channel is stopped, the same write also loads the counter. The host reads back a byte of the channel's visible value through a combinational read port. In event mode a channel can count the underflows of a fixed neighbour. The neighbours form rings: the channel at the start of a ring takes the last channel of that ring, and every other channel takes the channel just below it. The default build has two rings of three, (0,1,2) and (3,4,5). Each underflow and each capture raises a one-cycle interrupt request.

Top module: `tmr_ring_group`

## Requirements
- R1: After reset, every counter and reload register reads 0, and all `irq` and `uflow` bits are 0.
- R2: A byte write stores `wr_data` into the reload register, low byte when `wr_hi`=0 (bits 7:0) and high byte when `wr_hi`=1 (bits 15:8). If the channel's start bit is 0, the same byte of the counter is loaded too.
- R3: While a channel's start bit is 0, its counter does not change except through host writes, whatever enables or edges arrive.
- R4: In timer mode (mode 00) a running counter decrements once per pulse of `clk_en[src]`. The source indices are 0 = fastest, 1 = /8, 2 = /32, 3 = low-speed. Pulses on the other enables have no effect.
- R5: A running counter at 0 that receives a count pulse reloads from the reload register. In the cycle after that edge, `irq` and `uflow` of the channel are 1 for exactly one cycle.
- R6: A byte write to a running channel changes only the reload register. The counter keeps its value, and the new value takes effect at the next underflow.
- R7: In event mode (mode 01) with `src[1]`=0, the counter decrements on edges of its pin. The edge field selects the edges: 00 = falling, 01 = rising, 10 or 11 = both.
- R8: In event mode with `src[1]`=1, the counter decrements once per `uflow` pulse of its neighbour. The neighbour of channel i is i-1, except that the first channel of each ring takes the last channel of that ring (channel 0 takes 2, channel 3 takes 5).
- R9: In measurement mode (mode 10), a running counter increments on `clk_en[src]`. At each qualifying pin edge it copies its value into the reload register, clears to 0, and pulses `irq` but not `uflow`. Edge field 00 or 01 gives period measurement on one polarity, and 10 or 11 gives width measurement on both edges. A capture takes priority over a host write.
- R10: `rd_data` shows byte `rd_hi` of channel `rd_ch`'s counter in modes 00, 01 and 11, and of its reload (capture) register in mode 10.
- R11: Mode 11 never changes the counter, even with the start bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 4 | Prescaled one-cycle count enables, index = source code |
| ext_pin | input | 6 | Per-channel external input |
| mode | input | 12 | 2-bit mode per channel (channel i at bits 2i+1:2i) |
| src | input | 12 | 2-bit source select per channel |
| edge_sel | input | 12 | 2-bit edge select per channel |
| start | input | 6 | Per-channel run enable |
| wr_en | input | 1 | Host byte write strobe |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| wr_data | input | 8 | Write byte |
| rd_ch | input | 3 | Channel addressed by the read |
| rd_hi | input | 1 | 1 selects the high byte of the read |
| rd_data | output | 8 | Read byte (combinational) |
| irq | output | 6 | One-cycle interrupt request per channel |
| uflow | output | 6 | One-cycle underflow pulse per channel (cascade output) |

## Verification
The bench builds the group with its default parameters, two rings of three channels. With that build both ring-closing links can be tested: channel 0 fed from channel 2 and channel 3 fed from channel 5. A countdown table drives the reload and underflow paths with reload values of 0, small values and 0xFFFF. Directed cases then cover each pin-edge selection, one measurement in period mode and one in width mode, cascaded counting across a ring boundary, and the hold behaviour of a stopped channel and of the unused mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_CLK_EN = 4;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_MEAS  = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e      mode;
        logic [1:0] src;
        logic [1:0] edge_sel;
        logic       start;
    } chan_cfg_t;

    typedef struct packed {
        logic              lo;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } host_wr_t;

    // Cascade source: first channel of a ring wraps to the ring's last channel.
    function automatic int ring_nbr(int idx, int ring_len);
        if ((idx % ring_len) == 0)
            return idx + ring_len - 1;
        return idx - 1;
    endfunction

    function automatic logic counts_down(mode_e m);
        return (m == MODE_TIMER) || (m == MODE_EVENT);
    endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       pulse
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign rise = pin & ~prev_q;
    assign fall = ~pin & prev_q;

    always_comb begin
        if (sel[1])      pulse = rise | fall;
        else if (sel[0]) pulse = rise;
        else             pulse = fall;
    end
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  chan_cfg_t              cfg,
    input  logic [NUM_CLK_EN-1:0]  clk_en,
    input  logic                   pin_edge,
    input  logic                   casc_in,
    output logic                   tick
);
    always_comb begin
        unique case (cfg.mode)
            MODE_TIMER,
            MODE_MEAS:  tick = clk_en[cfg.src];
            MODE_EVENT: tick = cfg.src[1] ? casc_in : pin_edge;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  chan_cfg_t              cfg,
    input  logic [NUM_CLK_EN-1:0]  clk_en,
    input  logic                   pin,
    input  logic                   casc_in,
    input  host_wr_t               wr,
    output logic [CNT_W-1:0]       view,
    output logic                   irq,
    output logic                   uflow
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             pin_edge;
    logic             tick;

    tmr_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin   (pin),
        .sel   (cfg.edge_sel),
        .pulse (pin_edge)
    );

    tmr_tick_sel u_tick (
        .cfg      (cfg),
        .clk_en   (clk_en),
        .pin_edge (pin_edge),
        .casc_in  (casc_in),
        .tick     (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            irq   <= 1'b0;
            uflow <= 1'b0;
        end else begin
            irq   <= 1'b0;
            uflow <= 1'b0;
            if (wr.lo) begin
                rld_q[BYTE_W-1:0] <= wr.data;
                if (!cfg.start) cnt_q[BYTE_W-1:0] <= wr.data;
            end
            if (wr.hi) begin
                rld_q[CNT_W-1:BYTE_W] <= wr.data;
                if (!cfg.start) cnt_q[CNT_W-1:BYTE_W] <= wr.data;
            end
            if (cfg.start) begin
                if (counts_down(cfg.mode)) begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            cnt_q <= rld_q;
                            irq   <= 1'b1;
                            uflow <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end else if (cfg.mode == MODE_MEAS) begin
                    if (pin_edge) begin
                        rld_q <= cnt_q;
                        cnt_q <= '0;
                        irq   <= 1'b1;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign view = (cfg.mode == MODE_MEAS) ? rld_q : cnt_q;
endmodule

// File: rtl/tmr_ring_group.sv
module tmr_ring_group
    import tmr_pkg::*;
#(
    parameter int RING_LEN  = 3,
    parameter int NUM_RINGS = 2,
    localparam int NUM_CH   = RING_LEN * NUM_RINGS,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CLK_EN-1:0]   clk_en,
    input  logic [NUM_CH-1:0]       ext_pin,
    input  logic [2*NUM_CH-1:0]     mode,
    input  logic [2*NUM_CH-1:0]     src,
    input  logic [2*NUM_CH-1:0]     edge_sel,
    input  logic [NUM_CH-1:0]       start,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic                    wr_hi,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [CH_W-1:0]         rd_ch,
    input  logic                    rd_hi,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [NUM_CH-1:0]       irq,
    output logic [NUM_CH-1:0]       uflow
);
    logic [CNT_W-1:0] view [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int NBR = ring_nbr(i, RING_LEN);
        chan_cfg_t cfg_i;
        host_wr_t  wr_i;
        logic      hit;

        assign hit = wr_en && (wr_ch == CH_W'(i));
        assign cfg_i.mode     = mode_e'(mode[2*i +: 2]);
        assign cfg_i.src      = src[2*i +: 2];
        assign cfg_i.edge_sel = edge_sel[2*i +: 2];
        assign cfg_i.start    = start[i];
        assign wr_i.lo        = hit && !wr_hi;
        assign wr_i.hi        = hit && wr_hi;
        assign wr_i.data      = wr_data;

        tmr_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_i),
            .clk_en  (clk_en),
            .pin     (ext_pin[i]),
            .casc_in (uflow[NBR]),
            .wr      (wr_i),
            .view    (view[i]),
            .irq     (irq[i]),
            .uflow   (uflow[i])
        );
    end

    always_comb begin
        logic [CNT_W-1:0] sel_val;
        sel_val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) sel_val = view[i];
        end
        rd_data = rd_hi ? sel_val[CNT_W-1:BYTE_W] : sel_val[BYTE_W-1:0];
    end
endmodule

// File: rtl/tmr_chan_checker.sv
module tmr_chan_checker
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input chan_cfg_t        cfg,
    input logic             tick,
    input logic             pin_edge,
    input host_wr_t         wr,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rld_q,
    input logic             irq,
    input logic             uflow
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.start && !wr.lo && !wr.hi) |=> $stable(cnt_q));

    p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.start && counts_down(cfg.mode) && tick && cnt_q != '0)
        |=> cnt_q == ($past(cnt_q) - ONE));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.start && counts_down(cfg.mode) && tick && cnt_q == '0)
        |=> (cnt_q == $past(rld_q)) && irq && uflow);

    p_uflow_irq_r5: assert property (@(posedge clk) disable iff (rst)
        uflow |-> irq);

    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.start && cfg.mode == MODE_MEAS && pin_edge)
        |=> (cnt_q == '0) && (rld_q == $past(cnt_q)) && irq && !uflow);
endmodule

bind tmr_channel tmr_chan_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .tick     (tick),
    .pin_edge (pin_edge),
    .wr       (wr),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .irq      (irq),
    .uflow    (uflow)
);

// File: tb/test_tmr_ring_group.sv
module test_tmr_ring_group;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    typedef struct packed {
        logic [15:0] rld;
        logic [15:0] n;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_irq;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{rld: 16'd5,      n: 16'd3,  exp_cnt: 16'd2,      exp_irq: 8'd0},
        '{rld: 16'd5,      n: 16'd6,  exp_cnt: 16'd5,      exp_irq: 8'd1},
        '{rld: 16'd0,      n: 16'd4,  exp_cnt: 16'd0,      exp_irq: 8'd4},
        '{rld: 16'h0102,   n: 16'd16, exp_cnt: 16'h00F2,   exp_irq: 8'd0},
        '{rld: 16'd2,      n: 16'd7,  exp_cnt: 16'd1,      exp_irq: 8'd2},
        '{rld: 16'hFFFF,   n: 16'd1,  exp_cnt: 16'hFFFE,   exp_irq: 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        clk_en = '0;
    logic [NCH-1:0]    ext_pin = '0;
    logic [2*NCH-1:0]  mode = '0;
    logic [2*NCH-1:0]  src = '0;
    logic [2*NCH-1:0]  edge_sel = '0;
    logic [NCH-1:0]    start = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_ch = '0;
    logic              wr_hi = 1'b0;
    logic [7:0]        wr_data = '0;
    logic [2:0]        rd_ch = '0;
    logic              rd_hi = 1'b0;
    logic [7:0]        rd_data;
    logic [NCH-1:0]    irq;
    logic [NCH-1:0]    uflow;

    int n_chk  = 0;
    int n_fail = 0;

    tmr_ring_group i_tmr_ring_group (
        .clk(clk), .rst(rst), .clk_en(clk_en), .ext_pin(ext_pin),
        .mode(mode), .src(src), .edge_sel(edge_sel), .start(start),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_hi(wr_hi), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_hi(rd_hi), .rd_data(rd_data),
        .irq(irq), .uflow(uflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic setup(int ch, logic [1:0] m, logic [1:0] s, logic [1:0] e);
        mode[2*ch +: 2]     = m;
        src[2*ch +: 2]      = s;
        edge_sel[2*ch +: 2] = e;
    endtask

    task automatic wr_byte(int ch, logic hi, logic [7:0] d);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_hi = hi; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic load(int ch, logic [15:0] v);
        start[ch] = 1'b0;
        wr_byte(ch, 1'b0, v[7:0]);
        wr_byte(ch, 1'b1, v[15:8]);
    endtask

    task automatic read16(int ch, output int v);
        logic [15:0] t;
        rd_ch = 3'(ch); rd_hi = 1'b0; #1; t[7:0] = rd_data;
        rd_hi = 1'b1; #1; t[15:8] = rd_data;
        v = int'(t);
    endtask

    task automatic ticks(int idx, int n, int ch, output int nirq);
        nirq = 0;
        for (int k = 0; k < n; k++) begin
            clk_en = 4'b0001 << idx;
            cyc();
            nirq += int'(irq[ch]);
        end
        clk_en = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired (all requirements)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        int ni;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            read16(c, v);
            chk("R1 reset value", v, 0);
        end
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 uflow after reset", int'(uflow), 0);

        // R2/R4/R5: countdown table on channel 0, /8 source
        for (int t = 0; t < 6; t++) begin
            setup(0, 2'b00, 2'b01, 2'b00);
            load(0, VEC[t].rld);
            read16(0, v);
            chk("R2 stopped write loads counter", v, int'(VEC[t].rld));
            start[0] = 1'b1;
            ticks(1, int'(VEC[t].n), 0, ni);
            read16(0, v);
            chk("R4 countdown value", v, int'(VEC[t].exp_cnt));
            chk("R5 underflow irq count", ni, int'(VEC[t].exp_irq));
            start[0] = 1'b0;
        end

        // R4: other enables ignored
        setup(0, 2'b00, 2'b01, 2'b00);
        load(0, 16'd20);
        start[0] = 1'b1;
        ticks(0, 3, 0, ni);
        ticks(2, 3, 0, ni);
        ticks(3, 3, 0, ni);
        read16(0, v);
        chk("R4 unselected enables ignored", v, 20);

        // R3: stopped channel holds
        start[0] = 1'b0;
        cyc();
        ticks(1, 5, 0, ni);
        read16(0, v);
        chk("R3 stopped counter holds", v, 20);

        // R6 and R5 pulse timing
        setup(0, 2'b00, 2'b00, 2'b00);
        load(0, 16'd4);
        start[0] = 1'b1;
        ticks(0, 1, 0, ni);
        wr_byte(0, 1'b0, 8'd9);
        read16(0, v);
        chk("R6 running write keeps counter", v, 3);
        ticks(0, 3, 0, ni);
        ticks(0, 1, 0, ni);
        chk("R5 irq on reload tick", int'(irq[0]), 1);
        chk("R5 uflow on reload tick", int'(uflow[0]), 1);
        read16(0, v);
        chk("R6 new reload used", v, 9);
        cyc();
        chk("R5 uflow one cycle", int'(uflow[0]), 0);
        start[0] = 1'b0;

        // R7: pin edges: sequence rise, fall, rise
        for (int e = 0; e < 3; e++) begin
            int expv;
            setup(1, 2'b01, 2'b00, 2'(e));
            ext_pin[1] = 1'b0;
            cyc();
            load(1, 16'd4);
            start[1] = 1'b1;
            ext_pin[1] = 1'b1; cyc();
            ext_pin[1] = 1'b0; cyc();
            ext_pin[1] = 1'b1; cyc();
            read16(1, v);
            expv = (e == 0) ? 3 : (e == 1) ? 2 : 1;
            chk("R7 pin edge count", v, expv);
            start[1] = 1'b0;
            ext_pin[1] = 1'b0;
            cyc();
        end

        // R8: cascade 0 -> 1
        setup(0, 2'b00, 2'b00, 2'b00);
        setup(1, 2'b01, 2'b10, 2'b00);
        load(0, 16'd1);
        load(1, 16'd5);
        start[0] = 1'b1; start[1] = 1'b1;
        ticks(0, 4, 0, ni);
        cyc();
        read16(1, v);
        chk("R8 cascade from channel 0", v, 3);
        start[0] = 1'b0; start[1] = 1'b0;

        // R8: ring wrap 5 -> 3
        setup(5, 2'b00, 2'b00, 2'b00);
        setup(3, 2'b01, 2'b10, 2'b00);
        load(5, 16'd0);
        load(3, 16'd10);
        start[5] = 1'b1; start[3] = 1'b1;
        ticks(0, 3, 5, ni);
        cyc();
        read16(3, v);
        chk("R8 ring wrap channel 5 feeds 3", v, 7);
        start[5] = 1'b0; start[3] = 1'b0;

        // R9: period measurement on rising edges
        setup(2, 2'b10, 2'b00, 2'b01);
        load(2, 16'd0);
        ext_pin[2] = 1'b0;
        start[2] = 1'b1;
        clk_en = 4'b0001;
        ext_pin[2] = 1'b1; cyc();
        ext_pin[2] = 1'b0;
        repeat (8) cyc();
        ext_pin[2] = 1'b1; cyc();
        chk("R9 period capture irq", int'(irq[2]), 1);
        chk("R9 capture no uflow", int'(uflow[2]), 0);
        read16(2, v);
        chk("R9 R10 period capture value", v, 8);

        // R9: width measurement, both edges
        setup(2, 2'b10, 2'b00, 2'b10);
        ext_pin[2] = 1'b0; cyc();
        ext_pin[2] = 1'b1; cyc();
        repeat (3) cyc();
        ext_pin[2] = 1'b0; cyc();
        read16(2, v);
        chk("R9 width capture value", v, 3);
        clk_en = '0;
        start[2] = 1'b0;
        cyc();

        // R11: unused mode never counts
        setup(4, 2'b11, 2'b00, 2'b10);
        load(4, 16'd7);
        start[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            clk_en = 4'b1111;
            ext_pin[4] = ~ext_pin[4];
            cyc();
        end
        clk_en = '0;
        read16(4, v);
        chk("R11 R10 unused mode holds", v, 7);
        start[4] = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule